// File: doc/BRIEF.md
# Split-Phase Nibble Clock Divider

This block divides a fast base clock down to the clock used by a removable-memory card interface. The high and low halves of each output period are set separately. An 8-bit divider field holds two 4-bit counts. The upper count sets the number of base cycles the output stays high, minus one, and the lower count sets the number of base cycles it stays low, minus one. The output period is therefore (upper+1)+(lower+1) base cycles. This allows odd division ratios such as 11 with no more than one cycle of imbalance between the two halves, and a field of zero gives the fastest output: half the base rate.

Software reaches the block through a small register port. The divider register is 16 bits wide, and a field-only write changes its low byte and leaves the rest alone. A path register selects how the card logic is clocked: a feedback-select bit and a stick-frequency-select bit. Two single-cycle prepare commands put the path register into the state needed for card use or for stick use. When the chip enters its lowest-power level, the fast base is stopped and the output follows a slow reference input instead. A new divider setting is taken up only when a low phase ends, so the output never shows a shortened pulse.

Top module: `nibble_clkdiv`

## Requirements
- R1: While not in low-power, each high phase of `clkOut` lasts (divider bits 7:4)+1 base cycles.
- R2: While not in low-power, each low phase of `clkOut` lasts (divider bits 3:0)+1 base cycles, and a new high phase starts only when that low count has run out.
- R3: After reset, `clkOut` is high. The divider register (read address 0) reads 0x0054 and the path register (read address 1) reads 0x0000. The first high phase lasts 6 cycles and the first low phase lasts 5 cycles.
- R4: A divider field of 0x00 gives a period of two cycles: one high and one low.
- R5: A divider write takes effect at the first high phase that begins after the write. The high phase in progress and the low phase after it keep their old lengths.
- R6: A write with `wrFieldOnly`=1 to address 0 changes only divider bits 7:0. A write with `wrFieldOnly`=0 replaces all 16 bits. A write to address 1 replaces the path register.
- R7: A `prepCard` pulse clears path bit 0 (feedback select, `fbSel`) and path bit 1 (stick frequency select, `stickSel`) and loads divider bits 7:0 with 0x54. All other bits of both registers are kept.
- R8: A `prepStick` pulse clears path bit 0, sets path bit 1 and leaves the divider register unchanged.
- R9: While `lowPower` is 1, `clkOut` equals `refIn` in the same cycle, whatever the divider setting.
- R10: In the first cycle after `lowPower` returns to 0, `clkOut` is high. This high phase lasts (bits 7:4)+1 cycles of the current divider field, and the low phase after it lasts (bits 3:0)+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 divider, 1 path register |
| wrFieldOnly | input | 1 | Divider write touches bits 7:0 only |
| wrData | input | 16 | Write data |
| rdAddr | input | 1 | Read select: 0 divider, 1 path register |
| rdData | output | 16 | Selected register contents |
| prepCard | input | 1 | Prepare the card path (one-cycle pulse) |
| prepStick | input | 1 | Prepare the stick path (one-cycle pulse) |
| lowPower | input | 1 | Lowest-power level active |
| refIn | input | 1 | Slow reference clock level |
| fbSel | output | 1 | Feedback clock select (path bit 0) |
| stickSel | output | 1 | Stick frequency select (path bit 1) |
| clkOut | output | 1 | Divided clock output |

## Verification
On every cycle, the assertions check four things: that each rising output edge outside low-power follows an expired low count, that the output starts high when low-power ends, that a field-only write keeps the upper divider byte, and that each prepare command leaves the path bits in its defined state. The exact length of each phase for every one of the 256 field values can only be shown by the bench's timed sweeps. The same holds for when a mid-phase write is taken up, and for the reference pass-through under a changing `refIn` pattern.

// File: rtl/nibble_clkdiv_pkg.sv
package nibble_clkdiv_pkg;
  // One action per base cycle, chosen by the phase controller
  typedef struct packed {
    logic restart;    // low-power: park in high phase with fresh counts
    logic enterLow;   // high count expired
    logic enterHigh;  // low count expired, pick up pending setting
    logic countDown;  // phase continues
  } divStrobes_t;
endpackage

// File: rtl/nibble_clkdiv_regs.sv
module nibble_clkdiv_regs #(
  parameter int REG_W = 16,
  parameter int FIELD_W = 8,
  parameter logic [REG_W-1:0] DIV_RESET = 16'h0054,
  parameter logic [FIELD_W-1:0] CARD_DEFAULT = 8'h54,
  parameter int FB_BIT = 0,
  parameter int STICK_BIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic             wrFieldOnly,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdAddr,
  input  logic             prepCard,
  input  logic             prepStick,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] divReg,
  output logic [REG_W-1:0] pathReg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= DIV_RESET;
      pathReg <= '0;
    end else begin
      if (wrEn && !wrAddr) begin
        if (wrFieldOnly) divReg[FIELD_W-1:0] <= wrData[FIELD_W-1:0];
        else             divReg <= wrData;
      end
      if (wrEn && wrAddr) pathReg <= wrData;
      // prepare commands override a same-cycle write on the bits they own
      if (prepCard) begin
        divReg[FIELD_W-1:0] <= CARD_DEFAULT;
        pathReg[FB_BIT]     <= 1'b0;
        pathReg[STICK_BIT]  <= 1'b0;
      end else if (prepStick) begin
        pathReg[FB_BIT]     <= 1'b0;
        pathReg[STICK_BIT]  <= 1'b1;
      end
    end
  end

  assign rdData = rdAddr ? pathReg : divReg;
endmodule

// File: rtl/nibble_clkdiv_ctl.sv
module nibble_clkdiv_ctl
  import nibble_clkdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowPower,
  input  logic        cntZero,
  output divStrobes_t strb,
  output logic        phaseHigh
);
  always_comb begin
    strb = '0;
    if (lowPower)       strb.restart   = 1'b1;
    else if (!cntZero)  strb.countDown = 1'b1;
    else if (phaseHigh) strb.enterLow  = 1'b1;
    else                strb.enterHigh = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phaseHigh <= 1'b1;
    else if (strb.restart)   phaseHigh <= 1'b1;
    else if (strb.enterLow)  phaseHigh <= 1'b0;
    else if (strb.enterHigh) phaseHigh <= 1'b1;
  end
endmodule

// File: rtl/nibble_clkdiv_dp.sv
module nibble_clkdiv_dp
  import nibble_clkdiv_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter logic [2*NIB_W-1:0] FIELD_RESET = 8'h54
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobes_t        strb,
  input  logic [2*NIB_W-1:0] divField,
  input  logic               phaseHigh,
  input  logic               lowPower,
  input  logic               refIn,
  output logic               cntZero,
  output logic               clkOut
);
  localparam int FIELD_W = 2 * NIB_W;

  logic [NIB_W-1:0] cnt;
  logic [NIB_W-1:0] activeLo;
  logic [NIB_W-1:0] pendHi;
  logic [NIB_W-1:0] pendLo;

  assign pendHi = divField[FIELD_W-1:NIB_W];
  assign pendLo = divField[NIB_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= FIELD_RESET[FIELD_W-1:NIB_W];
      activeLo <= FIELD_RESET[NIB_W-1:0];
    end else if (strb.restart || strb.enterHigh) begin
      cnt      <= pendHi;
      activeLo <= pendLo;
    end else if (strb.enterLow) begin
      cnt      <= activeLo;
    end else if (strb.countDown) begin
      cnt      <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
  assign clkOut  = lowPower ? refIn : phaseHigh;
endmodule

// File: rtl/nibble_clkdiv.sv
module nibble_clkdiv
  import nibble_clkdiv_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] DIV_RESET = 16'h0054,
  parameter logic [2*NIB_W-1:0] CARD_DEFAULT = 8'h54
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic             wrFieldOnly,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdAddr,
  output logic [REG_W-1:0] rdData,
  input  logic             prepCard,
  input  logic             prepStick,
  input  logic             lowPower,
  input  logic             refIn,
  output logic             fbSel,
  output logic             stickSel,
  output logic             clkOut
);
  localparam int FIELD_W = 2 * NIB_W;

  logic [REG_W-1:0] divReg;
  logic [REG_W-1:0] pathReg;
  divStrobes_t      strb;
  logic             cntZero;
  logic             phaseHigh;

  nibble_clkdiv_regs #(
    .REG_W(REG_W), .FIELD_W(FIELD_W), .DIV_RESET(DIV_RESET),
    .CARD_DEFAULT(CARD_DEFAULT), .FB_BIT(0), .STICK_BIT(1)
  ) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrFieldOnly(wrFieldOnly), .wrData(wrData), .rdAddr(rdAddr),
    .prepCard(prepCard), .prepStick(prepStick), .rdData(rdData),
    .divReg(divReg), .pathReg(pathReg)
  );

  nibble_clkdiv_ctl ctl_i (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .cntZero(cntZero),
    .strb(strb), .phaseHigh(phaseHigh)
  );

  nibble_clkdiv_dp #(
    .NIB_W(NIB_W), .FIELD_RESET(DIV_RESET[FIELD_W-1:0])
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .divField(divReg[FIELD_W-1:0]),
    .phaseHigh(phaseHigh), .lowPower(lowPower), .refIn(refIn),
    .cntZero(cntZero), .clkOut(clkOut)
  );

  assign fbSel    = pathReg[0];
  assign stickSel = pathReg[1];
endmodule

// File: rtl/nibble_clkdiv_chk.sv
module nibble_clkdiv_chk
  import nibble_clkdiv_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int FIELD_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrAddr,
  input logic             wrFieldOnly,
  input logic             prepCard,
  input logic             prepStick,
  input logic             lowPower,
  input logic             cntZero,
  input logic             phaseHigh,
  input logic             clkOut,
  input logic [REG_W-1:0] divReg,
  input logic [REG_W-1:0] pathReg,
  input divStrobes_t      strb
);
  assert_one_action_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  assert_rise_after_low_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!lowPower && !$past(lowPower) && $rose(phaseHigh)) |-> $past(cntZero));

  assert_field_write_keeps_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr && wrFieldOnly) |=> divReg[REG_W-1:FIELD_W] == $past(divReg[REG_W-1:FIELD_W]));

  assert_card_prep_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    prepCard |=> (pathReg[1:0] == 2'b00) && (divReg[FIELD_W-1:0] == 8'h54));

  assert_stick_prep_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (prepStick && !prepCard) |=> (pathReg[1:0] == 2'b10));

  assert_exit_starts_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lowPower) |-> clkOut);
endmodule

bind nibble_clkdiv nibble_clkdiv_chk #(.REG_W(REG_W), .FIELD_W(FIELD_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrFieldOnly(wrFieldOnly),
  .prepCard(prepCard), .prepStick(prepStick), .lowPower(lowPower),
  .cntZero(cntZero), .phaseHigh(phaseHigh), .clkOut(clkOut),
  .divReg(divReg), .pathReg(pathReg), .strb(strb)
);

// File: tb/nibble_clkdiv_tb_top.sv
`timescale 1ns/1ps
module nibble_clkdiv_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrAddr = 1'b0, wrFieldOnly = 1'b0;
  logic [15:0] wrData = '0;
  logic rdAddr = 1'b0;
  logic [15:0] rdData;
  logic prepCard = 1'b0, prepStick = 1'b0, lowPower = 1'b0, refIn = 1'b0;
  logic fbSel, stickSel, clkOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  nibble_clkdiv dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrFieldOnly(wrFieldOnly),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .prepCard(prepCard),
    .prepStick(prepStick), .lowPower(lowPower), .refIn(refIn), .fbSel(fbSel),
    .stickSel(stickSel), .clkOut(clkOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic addr, input logic fieldOnly, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = addr; wrFieldOnly = fieldOnly; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrFieldOnly = 1'b0;
  endtask

  task automatic regRead(input logic addr, output logic [15:0] d);
    rdAddr = addr; #0.5; d = rdData;
  endtask

  task automatic runLen(input logic lvl, output int n);
    n = 0;
    while (clkOut == lvl && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitRise();
    int guard = 0;
    logic prev = clkOut;
    @(negedge clk);
    while (!(clkOut && !prev) && guard < 100) begin
      prev = clkOut;
      guard++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] rd;
    int h, l, h2, l2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    check("R3 clkOut", int'(clkOut), 1);
    regRead(1'b0, rd); check("R3 divider reset", int'(rd), 16'h0054);
    regRead(1'b1, rd); check("R3 path reset", int'(rd), 16'h0000);
    runLen(1'b1, h); runLen(1'b0, l);
    check("R3 first high", h, 6);
    check("R3 first low", l, 5);

    // exhaustive sweep of the divider field
    for (int v = 0; v < 256; v++) begin
      regWrite(1'b0, 1'b1, 16'(v));
      waitRise(); waitRise();
      runLen(1'b1, h); runLen(1'b0, l);
      check("R1 high length", h, (v >> 4) + 1);
      check("R2 low length", l, (v & 15) + 1);
      if (v == 0) check("R4 period", h + l, 2);
    end

    // R5: mid-period write keeps current phases
    regWrite(1'b0, 1'b1, 16'h0033);
    waitRise(); waitRise();
    regWrite(1'b0, 1'b1, 16'h0075);
    runLen(1'b1, h); runLen(1'b0, l); runLen(1'b1, h2); runLen(1'b0, l2);
    check("R5 old high kept", h + 1, 4);
    check("R5 old low kept", l, 4);
    check("R5 new high", h2, 8);
    check("R5 new low", l2, 6);

    // R6: full and field writes
    regWrite(1'b0, 1'b0, 16'hA533);
    regRead(1'b0, rd); check("R6 full write", int'(rd), 16'hA533);
    regWrite(1'b0, 1'b1, 16'h5F21);
    regRead(1'b0, rd); check("R6 field write", int'(rd), 16'hA521);
    regWrite(1'b1, 1'b0, 16'hFFFF);
    regRead(1'b1, rd); check("R6 path write", int'(rd), 16'hFFFF);

    // R7: card prepare
    prepCard = 1'b1; @(negedge clk); prepCard = 1'b0;
    regRead(1'b1, rd); check("R7 path bits", int'(rd), 16'hFFFC);
    regRead(1'b0, rd); check("R7 divider field", int'(rd), 16'hA554);
    check("R7 fbSel", int'(fbSel), 0);
    check("R7 stickSel", int'(stickSel), 0);

    // R8: stick prepare
    regWrite(1'b1, 1'b0, 16'h0001);
    prepStick = 1'b1; @(negedge clk); prepStick = 1'b0;
    regRead(1'b1, rd); check("R8 path bits", int'(rd), 16'h0002);
    check("R8 fbSel", int'(fbSel), 0);
    check("R8 stickSel", int'(stickSel), 1);
    regRead(1'b0, rd); check("R8 divider untouched", int'(rd), 16'hA554);

    // R9: low-power follows reference
    regWrite(1'b0, 1'b1, 16'h0021);
    lowPower = 1'b1;
    for (int i = 0; i < 16; i++) begin
      refIn = ((16'h9C5A >> i) & 1) != 0;
      #0.5;
      check("R9 follow ref", int'(clkOut), int'(refIn));
      @(negedge clk);
    end
    refIn = 1'b0;
    // R10: exit restarts in high phase
    lowPower = 1'b0;
    #0.5;
    check("R10 starts high", int'(clkOut), 1);
    runLen(1'b1, h); runLen(1'b0, l);
    check("R10 high length", h, 3);
    check("R10 low length", l, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule